// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits between a byte-wide host bus and a raw NAND flash device. The host configures it through a fixed configuration page, which holds a window-enable bit and a 32-bit relocatable base address. Once the window is enabled, a second page is decoded at the programmed base. That page holds the flash data port, a mode register, a constant status byte, an interrupt status register and an interrupt mask register.

The mode register drives the flash control pins directly. These are command latch, address latch, active-low chip enable and write protect. The mode register also carries a two-bit error-correction command field, and the block turns some of its codes into a one-cycle clear pulse for an external accumulator.

Writes to the data port put a byte on the flash output bus with a one-cycle write strobe. Reads from the data port raise a read strobe in the same cycle and return the sampled flash byte on the next cycle. A single interrupt line combines status and mask, and it is gated by a master bit in the mask register.

All host reads are registered: `bus_rdata` updates on the clock edge that accepts `bus_rd`.

Top module: `nand_host_regs`

## Requirements
- R1: After reset the mode, interrupt status, interrupt mask and base address are zero and the window is disabled. The pins therefore read CLE=0, ALE=0, CE#=1, WP=0, and irq=0.
- R2: The configuration page is the host page whose address bits above bit 7 equal 1. In that page, offset 0x04 is the command register. Writing it stores bit 1 as the window enable, and a read returns 0x02 when enabled and 0x00 when disabled.
- R3: Configuration offsets 0x10, 0x11, 0x12 and 0x13 hold base address bits 7:0, 15:8, 23:16 and 31:24 respectively. A byte write changes only its own lane, and each lane reads back what was written.
- R4: The operating page is decoded only when the window is enabled, the page is neither 0 nor 1, and address bits 31:8 equal base bits 31:8. Otherwise, accesses to that page read 0 and writes leave all state unchanged.
- R5: Operating offset 0x04 is the mode register and reads back as written. Mode bit 0 drives CLE, bit 1 drives ALE, bit 7 drives WP, and CE# is the inverse of bit 4. Each pin follows one cycle after the write.
- R6: Mode bits 6:5 form an error-correction command. A mode write with code 01 or 11 gives `ecc_clr` high for exactly one cycle. Codes 00 and 10 give no pulse.
- R7: A write to operating offsets 0x00 to 0x03 drives `nf_dout` with the byte and raises `nf_we` for one cycle. It also sets interrupt status bit 0 and leaves the other status bits unchanged.
- R8: A read of operating offsets 0x00 to 0x03 raises `nf_re` in the same cycle as `bus_rd`, and returns the `nf_din` value of that cycle. `nf_re` stays low for all other accesses.
- R9: Operating offset 0x05 reads the constant 0x14.
- R10: Operating offsets 0x06 (interrupt status) and 0x07 (interrupt mask) are fully writable and read back as written.
- R11: `irq` is high exactly when mask bit 7 is set and the bitwise AND of mask and status is nonzero. It follows the register contents combinationally.
- R12: Offsets 0x08 to 0xFF of the operating page and offsets other than 0x04 and 0x10 to 0x13 of the configuration page read 0, and writes to them have no effect. Page 0 also reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Host write request, one cycle |
| bus_rd | input | 1 | Host read request, one cycle |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Registered read byte |
| nf_din | input | 8 | Byte from flash I/O |
| nf_dout | output | 8 | Byte to flash I/O |
| nf_we | output | 1 | Flash write strobe |
| nf_re | output | 1 | Flash read strobe |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp | output | 1 | Write protect |
| ecc_clr | output | 1 | Error-correction accumulator clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
Directed accesses first hit each register in both windows. They then toggle the window on and off, and move the base to a new page, so that decode gating is separated from plain offset mapping. Every error-correction code is written once to tell pulse codes from silent ones. Mask and status patterns cover three cases: master bit clear with matching bits, master bit set with no overlap, and overlap through a data write.

A seeded random phase mixes accesses to:
- the configuration page,
- the current base page,
- page 0,
- unrelated pages.

This phase uses random offsets and data, and it checks every read and every pin against a bench model after each access.

// File: rtl/nhr_pkg.sv
// Shared constants and types for the NAND host register interface.
// Assumes byte-wide host accesses and a 256-byte page per register window.
package nhr_pkg;
    localparam logic [7:0] CFG_CMD_OFF   = 8'h04;
    localparam logic [7:0] CFG_BASE_OFF  = 8'h10;
    localparam logic [7:0] OP_MODE_OFF   = 8'h04;
    localparam logic [7:0] OP_STAT_OFF   = 8'h05;
    localparam logic [7:0] OP_ISR_OFF    = 8'h06;
    localparam logic [7:0] OP_IMR_OFF    = 8'h07;
    localparam logic [7:0] STATUS_CONST  = 8'h14;
    localparam int         PAGE_SHIFT    = 8;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CFG  = 2'd1,
        RG_OP   = 2'd2
    } region_e;
endpackage

// File: rtl/nhr_decode.sv
// Address decoder: splits the host address into page and offset and picks
// the target window. The configuration page (1) wins over the base match,
// and page 0 is never claimed. Assumes ADDR_W <= BASE_W.
module nhr_decode
    import nhr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    input  logic [BASE_W-1:0] base,
    output region_e           region,
    output logic [7:0]        off
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] base_page;

    assign page      = addr[ADDR_W-1:PAGE_SHIFT];
    assign base_page = base[ADDR_W-1:PAGE_SHIFT];
    assign off       = addr[7:0];

    // Select the window that owns the current page.
    always_comb begin
        if (page == PAGE_W'(1))
            region = RG_CFG;
        else if (page != '0 && win_en && page == base_page)
            region = RG_OP;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/nhr_cfg_regs.sv
// Configuration page registers: the window-enable command bit and the
// relocatable base address split into byte lanes. Assumes wr_en is already
// qualified by the configuration-page decode.
module nhr_cfg_regs
    import nhr_pkg::*;
#(
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic [BASE_W-1:0] base,
    output logic [7:0]        rdata
);
    localparam int LANES = BASE_W / 8;

    logic [7:0] lane_q [LANES];

    // Command register: only bit 1 is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_en <= 1'b0;
        else if (wr_en && off == CFG_CMD_OFF)
            win_en <= wdata[1];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane of the base address, written independently.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= 8'h00;
            else if (wr_en && off == 8'(int'(CFG_BASE_OFF) + g))
                lane_q[g] <= wdata;
        end
        assign base[g*8 +: 8] = lane_q[g];
    end

    // Read mux for the configuration page.
    always_comb begin
        rdata = 8'h00;
        if (off == CFG_CMD_OFF)
            rdata = {6'b0, win_en, 1'b0};
        for (int i = 0; i < LANES; i++)
            if (off == 8'(int'(CFG_BASE_OFF) + i))
                rdata = lane_q[i];
    end

    // R2
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_en) |-> $past(wr_en && off == CFG_CMD_OFF));
endmodule

// File: rtl/nhr_op_regs.sv
// Operating page registers: flash data port, mode pins, error-correction
// command pulse, interrupt status and mask, and the interrupt output.
// Assumes wr_en and rd_en are already qualified by the operating-page decode.
module nhr_op_regs
    import nhr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] off,
    input  logic [7:0] wdata,
    input  logic [7:0] nf_din,
    output logic [7:0] rdata,
    output logic [7:0] nf_dout,
    output logic       nf_we,
    output logic       nf_re,
    output logic       nf_cle,
    output logic       nf_ale,
    output logic       nf_ce_n,
    output logic       nf_wp,
    output logic       ecc_clr,
    output logic       irq
);
    logic [7:0] mode_q;
    logic [7:0] isr_q;
    logic [7:0] imr_q;
    logic       is_data;
    logic       mode_wr;

    assign is_data = (off[7:2] == 6'd0);
    assign mode_wr = wr_en && off == OP_MODE_OFF;
    assign nf_re   = rd_en && is_data;

    // Mode register, which drives the flash control pins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 8'h00;
        else if (mode_wr)
            mode_q <= wdata;
    end

    // Clear pulse for the enable (01) and reset (11) command codes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ecc_clr <= 1'b0;
        else
            ecc_clr <= mode_wr && (wdata[6:5] == 2'b01 || wdata[6:5] == 2'b11);
    end

    // Interrupt status: host-writable, with bit 0 set by data writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= 8'h00;
        else if (wr_en && off == OP_ISR_OFF)
            isr_q <= wdata;
        else if (wr_en && is_data)
            isr_q[0] <= 1'b1;
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            imr_q <= 8'h00;
        else if (wr_en && off == OP_IMR_OFF)
            imr_q <= wdata;
    end

    // Flash write strobe and output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nf_we   <= 1'b0;
            nf_dout <= 8'h00;
        end else begin
            nf_we <= wr_en && is_data;
            if (wr_en && is_data)
                nf_dout <= wdata;
        end
    end

    assign nf_cle  = mode_q[0];
    assign nf_ale  = mode_q[1];
    assign nf_ce_n = ~mode_q[4];
    assign nf_wp   = mode_q[7];
    assign irq     = imr_q[7] && |(imr_q & isr_q);

    // Read mux for the operating page.
    always_comb begin
        if (is_data)
            rdata = nf_din;
        else begin
            case (off)
                OP_MODE_OFF: rdata = mode_q;
                OP_STAT_OFF: rdata = STATUS_CONST;
                OP_ISR_OFF:  rdata = isr_q;
                OP_IMR_OFF:  rdata = imr_q;
                default:     rdata = 8'h00;
            endcase
        end
    end

    // R7
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_data) |=> (nf_we && isr_q[0] && nf_dout == $past(wdata)));
    // R11
    irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !imr_q[7] |-> !irq);
    // R6
    ecc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |-> mode_q[5]);
    // R5
    ce_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_ce_n) |-> $past(mode_wr));
endmodule

// File: rtl/nand_host_regs.sv
// Top of the NAND host register interface: decodes the host byte bus into
// the configuration and operating windows and registers the read data.
// Assumes bus_wr and bus_rd are never high in the same cycle.
module nand_host_regs
    import nhr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        nf_din,
    output logic [7:0]        nf_dout,
    output logic              nf_we,
    output logic              nf_re,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_wp,
    output logic              ecc_clr,
    output logic              irq
);
    region_e           region;
    logic [7:0]        off;
    logic              win_en;
    logic [BASE_W-1:0] base;
    logic [7:0]        cfg_rdata;
    logic [7:0]        op_rdata;

    nhr_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_decode (
        .addr   (bus_addr),
        .win_en (win_en),
        .base   (base),
        .region (region),
        .off    (off)
    );

    nhr_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && region == RG_CFG),
        .off    (off),
        .wdata  (bus_wdata),
        .win_en (win_en),
        .base   (base),
        .rdata  (cfg_rdata)
    );

    nhr_op_regs u_op (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && region == RG_OP),
        .rd_en   (bus_rd && region == RG_OP),
        .off     (off),
        .wdata   (bus_wdata),
        .nf_din  (nf_din),
        .rdata   (op_rdata),
        .nf_dout (nf_dout),
        .nf_we   (nf_we),
        .nf_re   (nf_re),
        .nf_cle  (nf_cle),
        .nf_ale  (nf_ale),
        .nf_ce_n (nf_ce_n),
        .nf_wp   (nf_wp),
        .ecc_clr (ecc_clr),
        .irq     (irq)
    );

    // Registered host read data, taken from the window that owns the page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_rd) begin
            case (region)
                RG_CFG:  bus_rdata <= cfg_rdata;
                RG_OP:   bus_rdata <= op_rdata;
                default: bus_rdata <= 8'h00;
            endcase
        end
    end

    // R8
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nf_re |=> bus_rdata == $past(nf_din));
    // R4
    win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_re || ecc_clr) |-> win_en || $past(win_en));
endmodule

// File: tb/test_nand_host_regs.sv
`timescale 1ns/1ps
module test_nand_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0, nf_din = '0;
    logic [7:0]  bus_rdata, nf_dout;
    logic        nf_we, nf_re, nf_cle, nf_ale, nf_ce_n, nf_wp, ecc_clr, irq;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    bit          en_m;
    logic [31:0] base_m;
    logic [7:0]  mode_m, isr_m, imr_m;

    always #2 clk = ~clk;

    nand_host_regs i_nand_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nf_din(nf_din), .nf_dout(nf_dout), .nf_we(nf_we), .nf_re(nf_re),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_wp(nf_wp),
        .ecc_clr(ecc_clr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // 0 none, 1 cfg, 2 op
    function automatic int region_of(input logic [31:0] a);
        if (a[31:8] == 24'd1) return 1;
        if (a[31:8] != 24'd0 && en_m && a[31:8] == base_m[31:8]) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [31:0] a, input logic [7:0] din);
        int r = region_of(a);
        logic [7:0] o = a[7:0];
        if (r == 1) begin
            if (o == 8'h04) return {6'b0, en_m, 1'b0};
            if (o >= 8'h10 && o <= 8'h13) return base_m[(o-8'h10)*8 +: 8];
            return 8'h00;
        end
        if (r == 2) begin
            if (o < 8'h04) return din;
            case (o)
                8'h04: return mode_m;
                8'h05: return 8'h14;
                8'h06: return isr_m;
                8'h07: return imr_m;
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    function automatic logic exp_irq();
        return imr_m[7] && |(imr_m & isr_m);
    endfunction

    task automatic chk_pins();
        chk("R5 cle", nf_cle, mode_m[0]);
        chk("R5 ale", nf_ale, mode_m[1]);
        chk("R5 ce_n", nf_ce_n, !mode_m[4]);
        chk("R5 wp", nf_wp, mode_m[7]);
        chk("R11 irq", irq, exp_irq());
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        int r = region_of(a);
        logic [7:0] o = a[7:0];
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (r == 1) begin
            if (o == 8'h04) en_m = d[1];
            if (o >= 8'h10 && o <= 8'h13) base_m[(o-8'h10)*8 +: 8] = d;
        end else if (r == 2) begin
            if (o < 8'h04) isr_m[0] = 1'b1;
            if (o == 8'h04) mode_m = d;
            if (o == 8'h06) isr_m = d;
            if (o == 8'h07) imr_m = d;
        end
        // R7 write strobe and byte
        chk("R7 we", nf_we, (r == 2 && o < 8'h04));
        if (r == 2 && o < 8'h04) chk("R7 dout", nf_dout, d);
        // R6 clear pulse
        chk("R6 ecc_clr", ecc_clr, (r == 2 && o == 8'h04 && d[5]));
        chk_pins();
    endtask

    task automatic rd(input logic [31:0] a, input string req);
        logic [7:0] din = 8'($urandom);
        logic [7:0] e;
        e = exp_rd(a, din);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; nf_din = din;
        #1;
        // R8 read strobe in the request cycle
        chk("R8 re", nf_re, (region_of(a) == 2 && a[7:0] < 8'h04));
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, e);
        chk_pins();
    endtask

    localparam logic [31:0] CFG = 32'h0000_0100;

    initial begin
        int seed;
        logic [31:0] ob;
        seed = $urandom(32'd4242);
        en_m = 0; base_m = '0; mode_m = '0; isr_m = '0; imr_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", nf_ce_n, 1'b1);
        chk("R1 cle", nf_cle, 1'b0);
        chk("R1 irq", irq, 1'b0);
        rd(CFG + 8'h04, "R1 cmd");
        rd(CFG + 8'h12, "R1 base");

        // R4 window disabled at base page
        wr(CFG + 8'h11, 8'h34);
        rd(32'h0000_3404, "R4 disabled mode");
        wr(32'h0000_3404, 8'hFF);
        chk("R4 ignored pins", nf_ce_n, 1'b1);

        // R2 enable
        wr(CFG + 8'h04, 8'h02);
        rd(CFG + 8'h04, "R2 cmd on");
        // R3 lanes
        wr(CFG + 8'h13, 8'hA5);
        wr(CFG + 8'h10, 8'h77);
        rd(CFG + 8'h10, "R3 lane0");
        rd(CFG + 8'h11, "R3 lane1");
        rd(CFG + 8'h13, "R3 lane3");
        ob = {base_m[31:8], 8'h00};

        // R5 mode pins
        wr(ob + 4, 8'h93);
        rd(ob + 4, "R5 mode rd");
        // R6 every code
        wr(ob + 4, 8'h20);
        wr(ob + 4, 8'h40);
        wr(ob + 4, 8'h60);
        wr(ob + 4, 8'h00);
        // R9
        rd(ob + 5, "R9 status");
        // R10 / R11
        wr(ob + 6, 8'h0E);
        wr(ob + 7, 8'h0E);
        chk("R11 no master", irq, 1'b0);
        wr(ob + 7, 8'h81);
        chk("R11 no overlap", irq, 1'b0);
        wr(ob + 2, 8'h5C);
        chk("R11 data sets irq", irq, 1'b1);
        rd(ob + 6, "R10 isr");
        rd(ob + 7, "R10 imr");
        // R8 data read
        rd(ob + 1, "R8 data");
        rd(ob + 3, "R8 data alias");
        // R12 unmapped
        wr(ob + 8'h40, 8'hFF);
        rd(ob + 8'h40, "R12 op unmapped");
        wr(CFG + 8'h20, 8'hFF);
        rd(CFG + 8'h20, "R12 cfg unmapped");
        wr(32'h0000_0004, 8'hFF);
        rd(32'h0000_0004, "R12 page0");
        // R2 disable
        wr(CFG + 8'h04, 8'h00);
        rd(CFG + 8'h04, "R2 cmd off");
        rd(ob + 6, "R4 disabled isr");
        wr(CFG + 8'h04, 8'h02);

        // random phase
        for (int n = 0; n < 400; n++) begin
            int k = int'($urandom % 6);
            logic [31:0] a;
            logic [7:0] o = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom);
            case (k)
                0: a = CFG + {24'd0, ($urandom % 3 == 0) ? 8'h04 : 8'(8'h10 + $urandom % 4)};
                1, 2, 3: a = {base_m[31:8], o};
                4: a = {24'd0, o};
                default: a = $urandom;
            endcase
            if ($urandom % 2) wr(a, 8'($urandom));
            else rd(a, "R4 random read");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule